// File: doc/BRIEF.md
# USB Endpoint Control Bank with Token Admission

This block holds the per-endpoint configuration for a USB device engine. There are sixteen identical endpoint slots, numbered 0 to 15. Each slot stores five control bits: handshake enable, control-disable, OUT enable, IN enable and halt. Firmware writes and reads the slots through a simple synchronous port. A firmware read returns the addressed slot combinationally.

The serial engine presents each decoded token as an endpoint number and a token kind, qualified by `tok_valid`. In the same cycle, the admission logic returns a verdict: ignore, accept or stall. It also returns a flag that tells the engine whether a handshake phase follows the data phase. The block has no back-pressure. A token is consumed in the cycle it is presented, and a verdict is valid only while `tok_valid` is high.

The engine can set an endpoint's halt bit with a one-cycle strobe, or clear every halt bit at once with its reset strobe. Firmware clears a halt by writing the bit to 0. If a stall strobe and a firmware write hit the same slot in the same cycle, the strobe wins.

Top module: `ep_ctrl_bank`

## Requirements
- R1: After `rst_n` is low, every slot reads back as 0x00, and every token is ignored.
- R2: A read returns {3'b000, hs_en, ctl_off, out_en, in_en, halt}, with hs_en at bit 4 and halt at bit 0. Write data in bits 7:5 is discarded.
- R3: A firmware write changes only the slot selected by `fw_addr`.
- R4: Token kind codes are 2'b01 OUT, 2'b10 IN, 2'b11 SETUP and 2'b00 none. A none token is never accepted. An OUT token is admitted only when out_en is 1. An IN token is admitted only when in_en is 1. ctl_off does not block OUT or IN tokens.
- R5: A SETUP token is admitted only when out_en=1, in_en=1 and ctl_off=0.
- R6: Verdict codes are 2'b00 ignore, 2'b01 accept and 2'b10 stall. Code 2'b11 never appears. The verdict is 2'b00 whenever `tok_valid` is low.
- R7: `hs_expect` is 1 exactly when the verdict is accept and hs_en of the addressed slot is 1.
- R8: A stall strobe sets the halt bit of its endpoint on the next clock edge. The bit stays set until firmware writes it to 0 or `eng_reset` is pulsed. `eng_reset` clears all halt bits and leaves the other bits unchanged.
- R9: An admitted token on a halted slot gets the stall verdict. The halt bit is ignored when the token is not admitted, for example when the slot has both directions disabled. Such a token gets the ignore verdict.
- R10: When a stall strobe and a firmware write or `eng_reset` hit the same slot in the same cycle, the halt bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of all slots |
| eng_reset | input | 1 | Engine reset strobe; clears every halt bit |
| fw_we | input | 1 | Firmware write enable |
| fw_addr | input | 4 | Firmware slot select for write and read |
| fw_wdata | input | 8 | Firmware write data |
| fw_rdata | output | 8 | Contents of the selected slot |
| stall_set_valid | input | 1 | Engine strobe that sets a halt bit |
| stall_set_ep | input | 4 | Endpoint targeted by the stall strobe |
| tok_valid | input | 1 | A decoded token is present |
| tok_ep | input | 4 | Endpoint number of the token |
| tok_kind | input | 2 | Token kind (none, OUT, IN, SETUP) |
| verdict | output | 2 | Admission result (ignore, accept, stall) |
| hs_expect | output | 1 | A handshake phase follows the data phase |

## Verification
Several properties are checked by assertions on every cycle:
- the upper read bits are always zero;
- verdict code 3 never appears, and the verdict is ignore while no token is present;
- a handshake is flagged only on an accepted token;
- the direction and SETUP gates hold against the stored slot bits;
- every stall strobe leaves its halt bit set, and an untouched halt bit stays set.

Other behaviour can only be shown by the bench's scenarios:
- an exhaustive sweep of all 32 configurations on every endpoint with every token kind shows that the verdict is right and that writes stay isolated per slot;
- directed scenarios show that a firmware write really clears a halt, that the engine reset leaves the other bits intact, and how same-cycle collisions resolve.

// File: rtl/ep_ctrl_pkg.sv
package ep_ctrl_pkg;

  // Slot layout. The first member of the packed struct is the MSB, so the
  // fields land on read bits 4..0.
  typedef struct packed {
    logic hs_en;    // bit 4: handshake phase enabled
    logic ctl_off;  // bit 3: SETUP traffic disabled
    logic out_en;   // bit 2: host-to-device direction enabled
    logic in_en;    // bit 1: device-to-host direction enabled
    logic halt;     // bit 0: endpoint halted
  } ep_cfg_t;

  localparam int CFG_W = $bits(ep_cfg_t);

  typedef enum logic [1:0] {
    TK_NONE  = 2'b00,
    TK_OUT   = 2'b01,
    TK_IN    = 2'b10,
    TK_SETUP = 2'b11
  } tok_kind_e;

  typedef enum logic [1:0] {
    VD_IGNORE = 2'b00,
    VD_ACCEPT = 2'b01,
    VD_STALL  = 2'b10
  } verdict_e;

endpackage

// File: rtl/ep_cfg_reg.sv
module ep_cfg_reg
  import ep_ctrl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_hit,
  input  ep_cfg_t wr_cfg,
  input  logic    halt_clr,
  input  logic    halt_set,
  output ep_cfg_t q
);

  ep_cfg_t nxt;

  // Priority, lowest first: firmware write, then engine clear, then stall set.
  always_comb begin
    nxt = q;
    if (wr_hit)   nxt = wr_cfg;
    if (halt_clr) nxt.halt = 1'b0;
    if (halt_set) nxt.halt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

endmodule

// File: rtl/ep_admit.sv
module ep_admit
  import ep_ctrl_pkg::*;
(
  input  logic       tok_valid,
  input  logic [1:0] tok_kind,
  input  ep_cfg_t    cfg,
  output logic [1:0] verdict,
  output logic       hs_expect
);

  logic permit;

  always_comb begin
    unique case (tok_kind)
      TK_OUT:   permit = cfg.out_en;
      TK_IN:    permit = cfg.in_en;
      TK_SETUP: permit = cfg.out_en & cfg.in_en & ~cfg.ctl_off;
      default:  permit = 1'b0;
    endcase
  end

  // The halt bit only matters for an admitted token, which implies at least
  // one direction is enabled.
  always_comb begin
    verdict   = VD_IGNORE;
    hs_expect = 1'b0;
    if (tok_valid && permit) begin
      if (cfg.halt) begin
        verdict = VD_STALL;
      end else begin
        verdict   = VD_ACCEPT;
        hs_expect = cfg.hs_en;
      end
    end
  end

endmodule

// File: rtl/ep_ctrl_bank.sv
module ep_ctrl_bank
  import ep_ctrl_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int REG_W  = 8,
  localparam int EP_W  = $clog2(NUM_EP),
  localparam int PAD_W = REG_W - CFG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eng_reset,
  input  logic             fw_we,
  input  logic [EP_W-1:0]  fw_addr,
  input  logic [REG_W-1:0] fw_wdata,
  output logic [REG_W-1:0] fw_rdata,
  input  logic             stall_set_valid,
  input  logic [EP_W-1:0]  stall_set_ep,
  input  logic             tok_valid,
  input  logic [EP_W-1:0]  tok_ep,
  input  logic [1:0]       tok_kind,
  output logic [1:0]       verdict,
  output logic             hs_expect
);

  ep_cfg_t ep_q [NUM_EP];
  ep_cfg_t wr_cfg;
  ep_cfg_t tok_cfg;

  // Bits above the slot width are dropped here.
  assign wr_cfg = ep_cfg_t'(fw_wdata[CFG_W-1:0]);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_slot
    ep_cfg_reg u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (fw_we && (fw_addr == EP_W'(i))),
      .wr_cfg   (wr_cfg),
      .halt_clr (eng_reset),
      .halt_set (stall_set_valid && (stall_set_ep == EP_W'(i))),
      .q        (ep_q[i])
    );
  end

  assign fw_rdata = {{PAD_W{1'b0}}, ep_q[fw_addr]};
  assign tok_cfg  = ep_q[tok_ep];

  ep_admit u_admit (
    .tok_valid (tok_valid),
    .tok_kind  (tok_kind),
    .cfg       (tok_cfg),
    .verdict   (verdict),
    .hs_expect (hs_expect)
  );

endmodule

// File: rtl/ep_ctrl_bank_chk.sv
module ep_ctrl_bank_chk
  import ep_ctrl_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int REG_W  = 8,
  localparam int EP_W  = $clog2(NUM_EP)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             eng_reset,
  input logic             fw_we,
  input logic [EP_W-1:0]  fw_addr,
  input logic [REG_W-1:0] fw_rdata,
  input logic             stall_set_valid,
  input logic [EP_W-1:0]  stall_set_ep,
  input logic             tok_valid,
  input logic [EP_W-1:0]  tok_ep,
  input logic [1:0]       tok_kind,
  input logic [1:0]       verdict,
  input logic             hs_expect,
  input ep_cfg_t          ep_q [NUM_EP]
);

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fw_rdata[REG_W-1:CFG_W] == '0);

  a_r6_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
    verdict != 2'b11);

  a_r6_idle_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |-> verdict == VD_IGNORE);

  a_r7_hs_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    hs_expect |-> (verdict == VD_ACCEPT) && ep_q[tok_ep].hs_en);

  a_r4_out_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == TK_OUT && !ep_q[tok_ep].out_en) |-> verdict == VD_IGNORE);

  a_r4_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == TK_IN && !ep_q[tok_ep].in_en) |-> verdict == VD_IGNORE);

  a_r5_setup_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == TK_SETUP && ep_q[tok_ep].ctl_off) |-> verdict == VD_IGNORE);

  a_r9_halt_only_if_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict == VD_STALL) |-> ep_q[tok_ep].halt && (ep_q[tok_ep].out_en || ep_q[tok_ep].in_en));

  a_r10_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    stall_set_valid |=> ep_q[$past(stall_set_ep)].halt);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_hold
    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_q[i].halt && !eng_reset && !(fw_we && fw_addr == EP_W'(i))) |=> ep_q[i].halt);
  end

endmodule

bind ep_ctrl_bank ep_ctrl_bank_chk #(.NUM_EP(NUM_EP), .REG_W(REG_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .eng_reset       (eng_reset),
  .fw_we           (fw_we),
  .fw_addr         (fw_addr),
  .fw_rdata        (fw_rdata),
  .stall_set_valid (stall_set_valid),
  .stall_set_ep    (stall_set_ep),
  .tok_valid       (tok_valid),
  .tok_ep          (tok_ep),
  .tok_kind        (tok_kind),
  .verdict         (verdict),
  .hs_expect       (hs_expect),
  .ep_q            (ep_q)
);

// File: tb/sim_ep_ctrl_bank.sv
module sim_ep_ctrl_bank;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       eng_reset = 1'b0;
  logic       fw_we = 1'b0;
  logic [3:0] fw_addr = '0;
  logic [7:0] fw_wdata = '0;
  logic [7:0] fw_rdata;
  logic       stall_set_valid = 1'b0;
  logic [3:0] stall_set_ep = '0;
  logic       tok_valid = 1'b0;
  logic [3:0] tok_ep = '0;
  logic [1:0] tok_kind = '0;
  logic [1:0] verdict;
  logic       hs_expect;

  int n_chk = 0;
  int n_bad = 0;
  logic [4:0] shadow [16];

  always #10 clk = ~clk;  // 50 MHz

  ep_ctrl_bank u0 (
    .clk(clk), .rst_n(rst_n), .eng_reset(eng_reset),
    .fw_we(fw_we), .fw_addr(fw_addr), .fw_wdata(fw_wdata), .fw_rdata(fw_rdata),
    .stall_set_valid(stall_set_valid), .stall_set_ep(stall_set_ep),
    .tok_valid(tok_valid), .tok_ep(tok_ep), .tok_kind(tok_kind),
    .verdict(verdict), .hs_expect(hs_expect)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected verdict computed from the requirements.
  function automatic logic [1:0] exp_vd(input logic [4:0] c, input logic v, input logic [1:0] k);
    logic ok;
    case (k)
      2'b01:   ok = c[2];
      2'b10:   ok = c[1];
      2'b11:   ok = c[2] & c[1] & ~c[3];
      default: ok = 1'b0;
    endcase
    if (!v || !ok) return 2'b00;
    return c[0] ? 2'b10 : 2'b01;
  endfunction

  task automatic fw_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    fw_we = 1'b1; fw_addr = a; fw_wdata = d;
    @(negedge clk);
    fw_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
    fw_addr = a;
    #1;
    chk(fw_rdata === exp, tag, fw_rdata, exp);
  endtask

  task automatic tok_chk(input logic [3:0] e, input logic v, input logic [1:0] k,
                         input logic [4:0] c, input string tag);
    logic [1:0] ev;
    tok_valid = v; tok_ep = e; tok_kind = k;
    #1;
    ev = exp_vd(c, v, k);
    chk(verdict === ev, tag, verdict, ev);
    chk(hs_expect === ((ev == 2'b01) && c[4]), "R7", hs_expect, (ev == 2'b01) && c[4]);
    tok_valid = 1'b0;
  endtask

  task automatic strobe_stall(input logic [3:0] e);
    @(negedge clk);
    stall_set_valid = 1'b1; stall_set_ep = e;
    @(negedge clk);
    stall_set_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of every slot and of admission
    for (int e = 0; e < 16; e++) begin
      shadow[e] = '0;
      rd_chk(4'(e), 8'h00, "R1");
      tok_chk(4'(e), 1'b1, 2'b11, 5'd0, "R1");
    end

    // Exhaustive sweep: every slot, every configuration, every token kind
    for (int e = 0; e < 16; e++) begin
      for (int c = 0; c < 32; c++) begin
        logic [4:0] cv;
        cv = 5'(c);
        fw_write(4'(e), {3'(c) | 3'b001, cv});   // junk in 7:5 (R2)
        shadow[e] = cv;
        rd_chk(4'(e), {3'b000, cv}, "R2");
        rd_chk(4'((e + 1) % 16), {3'b000, shadow[(e + 1) % 16]}, "R3");
        for (int k = 0; k < 4; k++) begin
          tok_chk(4'(e), 1'b1, 2'(k), cv,
                  (k == 3) ? "R5" : (cv[0] ? "R9" : "R4"));
        end
        tok_chk(4'(e), 1'b0, 2'b01, cv, "R6");
      end
    end

    // R8: stall strobe sets a sticky halt
    fw_write(4'd5, 8'h04);
    shadow[5] = 5'h04;
    strobe_stall(4'd5);
    rd_chk(4'd5, 8'h05, "R8");
    tok_chk(4'd5, 1'b1, 2'b01, 5'h05, "R9");
    rd_chk(4'd6, {3'b000, shadow[6]}, "R8");
    repeat (3) @(negedge clk);
    rd_chk(4'd5, 8'h05, "R8");

    // R10: same-cycle firmware write of 0 to halt loses to stall strobe
    @(negedge clk);
    fw_we = 1'b1; fw_addr = 4'd5; fw_wdata = 8'h14;
    stall_set_valid = 1'b1; stall_set_ep = 4'd5;
    @(negedge clk);
    fw_we = 1'b0; stall_set_valid = 1'b0;
    rd_chk(4'd5, 8'h15, "R10");

    // R8: firmware clears the halt
    fw_write(4'd5, 8'h14);
    rd_chk(4'd5, 8'h14, "R8");
    tok_chk(4'd5, 1'b1, 2'b01, 5'h14, "R8");

    // R9: halt on a disabled slot is ignored
    fw_write(4'd7, 8'h10);
    strobe_stall(4'd7);
    rd_chk(4'd7, 8'h11, "R9");
    tok_chk(4'd7, 1'b1, 2'b01, 5'h11, "R9");
    tok_chk(4'd7, 1'b1, 2'b10, 5'h11, "R9");

    // R8: engine reset clears all halts, keeps other bits
    strobe_stall(4'd5);
    rd_chk(4'd5, 8'h15, "R8");
    @(negedge clk);
    eng_reset = 1'b1;
    @(negedge clk);
    eng_reset = 1'b0;
    rd_chk(4'd5, 8'h14, "R8");
    rd_chk(4'd7, 8'h10, "R8");

    // R10: stall strobe wins over engine reset in the same cycle
    @(negedge clk);
    eng_reset = 1'b1; stall_set_valid = 1'b1; stall_set_ep = 4'd5;
    @(negedge clk);
    eng_reset = 1'b0; stall_set_valid = 1'b0;
    rd_chk(4'd5, 8'h15, "R10");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule